// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler Buffer

This block holds instructions after dispatch until they can be sent to execution. Each entry records a small identifier, the resource group it needs, and a tag plus a ready bit for every source operand. A writeback bus broadcasts one result tag per cycle. Every waiting entry compares its pending source tags against it and marks matching operands available. Once all of an entry's operands are available, it becomes eligible for issue.

Each resource group issues at most one instruction per cycle. The choice within a group always goes to the oldest eligible entry, whatever slot it sits in. The unit inside the group is picked by a rotating pointer, and units reported busy are skipped. An issued entry stays in the buffer until the execution side reports its slot complete. It is then freed, and the retire side gets the identifier. When every slot is occupied the block raises a stall flag, and dispatch requests are dropped while it is high.

Top module: `oo_issue_buffer`

## Requirements
- R1: After reset the buffer is empty: `full`, every `iss_valid` lane and `ret_valid` are low.
- R2: An entry dispatched with all sources ready appears on the issue outputs at the second rising edge after the dispatch edge, and never at the first.
- R3: A broadcast whose tag equals a pending source tag marks that source ready; an entry made fully ready this way issues at the second edge after the broadcast edge. A broadcast with a non-matching tag leaves the entry waiting.
- R4: A broadcast in the same cycle as a dispatch is applied to the new entry's source tags, so the entry behaves as if dispatched ready.
- R5: Within one group, when several entries are eligible, the one dispatched earliest issues first, regardless of slot index. Each group issues at most one entry per cycle, and different groups issue in parallel.
- R6: The unit index is chosen by a per-group pointer, starting at 0 after reset. The pick is the first non-busy unit at or after the pointer, wrapping around. After an issue the pointer moves one past the chosen unit. If every unit of a group is busy, that group issues nothing. `unit_busy` bit g*UNITS_PER_GRP+u belongs to unit u of group g.
- R7: A completion naming an issued slot frees it and raises `ret_valid` with that entry's identifier at the next edge. A completion naming a slot that is not in the issued state is ignored.
- R8: `full` is high exactly when all DEPTH slots hold entries. A dispatch while `full` is high is dropped and never issues.
- R9: Dispatch field `disp_grp` value g routes the entry to issue lane g. Lane g reports the identifier, slot and unit in bit fields g*ID_W, g*SLOT_W and g*UNIT_W. Source s uses tag bits s*TAG_W and ready bit s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_id | input | ID_W | Identifier of the dispatched instruction |
| disp_grp | input | GRP_W | Requested resource group |
| disp_tags | input | N_SRC*TAG_W | Source operand tags |
| disp_rdy | input | N_SRC | Source already available |
| full | output | 1 | All slots occupied; dispatch stalls |
| wb_valid | input | 1 | Writeback tag broadcast valid |
| wb_tag | input | TAG_W | Broadcast result tag |
| unit_busy | input | N_GROUPS*UNITS_PER_GRP | Execution unit cannot accept work |
| iss_valid | output | N_GROUPS | Issue per group lane |
| iss_id | output | N_GROUPS*ID_W | Issued identifier per lane |
| iss_slot | output | N_GROUPS*SLOT_W | Slot of the issued entry per lane |
| iss_unit | output | N_GROUPS*UNIT_W | Chosen unit within the group per lane |
| cmpl_valid | input | 1 | Execution completion |
| cmpl_slot | input | SLOT_W | Slot that completed |
| ret_valid | output | 1 | Completion forwarded to retire |
| ret_id | output | ID_W | Identifier of the completed entry |

## Verification
Entries are dispatched ready, waiting on one source, and waiting while a matching tag is broadcast in the same cycle. These three cases separate the normal dispatch-to-issue delay from the wakeup path and from a missed same-cycle wakeup. Age order is tested by placing a younger entry in a lower slot than an older one, so index-priority selection gives a different result from oldest-first. Unit selection is run with all units free, with the pointed-to unit busy, and with every unit busy. A filled buffer receives an extra dispatch and a completion for a waiting slot, and both must leave no trace in the issue and retire streams.

// File: rtl/oib_pkg.sv
package oib_pkg;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_READY  = 2'd2,
    ST_ISSUED = 2'd3
  } slot_state_e;

endpackage

// File: rtl/oib_slot.sv
module oib_slot
  import oib_pkg::*;
#(
  parameter int N_SRC = 2,
  parameter int TAG_W = 6,
  parameter int ID_W  = 8,
  parameter int GRP_W = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc,
  input  logic [ID_W-1:0]        a_id,
  input  logic [GRP_W-1:0]       a_grp,
  input  logic [N_SRC*TAG_W-1:0] a_tags,
  input  logic [N_SRC-1:0]       a_rdy,
  input  logic                   wb_valid,
  input  logic [TAG_W-1:0]       wb_tag,
  input  logic                   issue,
  input  logic                   retire_hit,
  output slot_state_e            state,
  output logic [ID_W-1:0]        id,
  output logic [GRP_W-1:0]       grp
);

  slot_state_e            state_q;
  logic [N_SRC-1:0]       rdy_q, rdy_n;
  logic [N_SRC*TAG_W-1:0] tags_q;
  logic [ID_W-1:0]        id_q;
  logic [GRP_W-1:0]       grp_q;

  // operand availability after this cycle's broadcast, for a new or a held entry
  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      if (alloc)
        rdy_n[s] = a_rdy[s] | (wb_valid && (a_tags[s*TAG_W +: TAG_W] == wb_tag));
      else
        rdy_n[s] = rdy_q[s] | (wb_valid && (tags_q[s*TAG_W +: TAG_W] == wb_tag));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FREE;
      rdy_q   <= '0;
    end else if (alloc) begin
      state_q <= (&rdy_n) ? ST_READY : ST_WAIT;
      rdy_q   <= rdy_n;
    end else begin
      case (state_q)
        ST_WAIT: begin
          rdy_q <= rdy_n;
          if (&rdy_n) state_q <= ST_READY;
        end
        ST_READY:  if (issue)      state_q <= ST_ISSUED;
        ST_ISSUED: if (retire_hit) state_q <= ST_FREE;
        default: ;
      endcase
    end
  end

  // payload without reset
  always_ff @(posedge clk) begin
    if (alloc) begin
      tags_q <= a_tags;
      id_q   <= a_id;
      grp_q  <= a_grp;
    end
  end

  assign state = state_q;
  assign id    = id_q;
  assign grp   = grp_q;

endmodule

// File: rtl/oib_age_matrix.sv
module oib_age_matrix #(
  parameter int DEPTH    = 8,
  parameter int N_GROUPS = 2,
  localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_en,
  input  logic [SLOT_W-1:0]         alloc_slot,
  input  logic [DEPTH-1:0]          occupied,
  input  logic [N_GROUPS*DEPTH-1:0] req,
  output logic [N_GROUPS*DEPTH-1:0] gnt
);

  // older_q[j][i] set: entry j was dispatched before entry i
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] col     [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(alloc_slot)) older_q[j] <= '0;
        else                       older_q[j][alloc_slot] <= occupied[j];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        col[i][j] = older_q[j][i];
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign gnt[g*DEPTH+i] = req[g*DEPTH+i] & ~(|(req[g*DEPTH +: DEPTH] & col[i]));
    end
  end

endmodule

// File: rtl/oib_rr_pick.sv
module oib_rr_pick #(
  parameter int N_UNITS = 2,
  localparam int UW     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_UNITS-1:0] busy,
  input  logic               take,
  output logic               any_free,
  output logic [UW-1:0]      pick
);

  logic [UW-1:0] ptr_q;

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int k = N_UNITS - 1; k >= 0; k--) begin
      if (!busy[(int'(ptr_q) + k) % N_UNITS]) begin
        any_free = 1'b1;
        pick     = UW'((int'(ptr_q) + k) % N_UNITS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (take)
      ptr_q <= (int'(pick) == N_UNITS - 1) ? '0 : pick + UW'(1);
  end

endmodule

// File: rtl/oo_issue_buffer.sv
module oo_issue_buffer
  import oib_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int N_SRC         = 2,
  parameter int TAG_W         = 6,
  parameter int ID_W          = 8,
  parameter int N_GROUPS      = 2,
  parameter int UNITS_PER_GRP = 2,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int GRP_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
  localparam int UNIT_W = (UNITS_PER_GRP > 1) ? $clog2(UNITS_PER_GRP) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              disp_valid,
  input  logic [ID_W-1:0]                   disp_id,
  input  logic [GRP_W-1:0]                  disp_grp,
  input  logic [N_SRC*TAG_W-1:0]            disp_tags,
  input  logic [N_SRC-1:0]                  disp_rdy,
  output logic                              full,
  input  logic                              wb_valid,
  input  logic [TAG_W-1:0]                  wb_tag,
  input  logic [N_GROUPS*UNITS_PER_GRP-1:0] unit_busy,
  output logic [N_GROUPS-1:0]               iss_valid,
  output logic [N_GROUPS*ID_W-1:0]          iss_id,
  output logic [N_GROUPS*SLOT_W-1:0]        iss_slot,
  output logic [N_GROUPS*UNIT_W-1:0]        iss_unit,
  input  logic                              cmpl_valid,
  input  logic [SLOT_W-1:0]                 cmpl_slot,
  output logic                              ret_valid,
  output logic [ID_W-1:0]                   ret_id
);

  slot_state_e       st   [DEPTH];
  logic [ID_W-1:0]   sid  [DEPTH];
  logic [GRP_W-1:0]  sgrp [DEPTH];

  logic [DEPTH-1:0]  occ, alloc_vec, issue_vec, ret_vec;
  logic [SLOT_W-1:0] alloc_slot;
  logic              free_found, alloc_en, ret_ok;

  logic [N_GROUPS*DEPTH-1:0] req, gnt;
  logic [N_GROUPS-1:0]       unit_ok, fire;
  logic [UNIT_W-1:0]         unit_pick [N_GROUPS];
  logic [SLOT_W-1:0]         gslot     [N_GROUPS];

  logic [N_GROUPS-1:0]        iss_valid_q;
  logic [N_GROUPS*ID_W-1:0]   iss_id_q;
  logic [N_GROUPS*SLOT_W-1:0] iss_slot_q;
  logic [N_GROUPS*UNIT_W-1:0] iss_unit_q;
  logic                       ret_valid_q;
  logic [ID_W-1:0]            ret_id_q;

  // lowest free slot takes the next dispatch
  always_comb begin
    free_found = 1'b0;
    alloc_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_found = 1'b1;
        alloc_slot = SLOT_W'(i);
      end
    end
  end

  assign full     = ~free_found;
  assign alloc_en = disp_valid & free_found;
  assign ret_ok   = cmpl_valid && (int'(cmpl_slot) < DEPTH) && (st[cmpl_slot] == ST_ISSUED);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign alloc_vec[i] = alloc_en && (alloc_slot == SLOT_W'(i));
    assign ret_vec[i]   = ret_ok && (cmpl_slot == SLOT_W'(i));
    assign occ[i]       = (st[i] != ST_FREE);

    oib_slot #(
      .N_SRC (N_SRC),
      .TAG_W (TAG_W),
      .ID_W  (ID_W),
      .GRP_W (GRP_W)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .alloc      (alloc_vec[i]),
      .a_id       (disp_id),
      .a_grp      (disp_grp),
      .a_tags     (disp_tags),
      .a_rdy      (disp_rdy),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .issue      (issue_vec[i]),
      .retire_hit (ret_vec[i]),
      .state      (st[i]),
      .id         (sid[i]),
      .grp        (sgrp[i])
    );
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    for (genvar i = 0; i < DEPTH; i++) begin : g_req
      assign req[g*DEPTH+i] = (st[i] == ST_READY) && (sgrp[i] == GRP_W'(g)) && unit_ok[g];
    end

    assign fire[g] = |gnt[g*DEPTH +: DEPTH];

    oib_rr_pick #(
      .N_UNITS (UNITS_PER_GRP)
    ) u_rr (
      .clk      (clk),
      .rst      (rst),
      .busy     (unit_busy[g*UNITS_PER_GRP +: UNITS_PER_GRP]),
      .take     (fire[g]),
      .any_free (unit_ok[g]),
      .pick     (unit_pick[g])
    );
  end

  oib_age_matrix #(
    .DEPTH    (DEPTH),
    .N_GROUPS (N_GROUPS)
  ) u_age (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc_en),
    .alloc_slot (alloc_slot),
    .occupied   (occ),
    .req        (req),
    .gnt        (gnt)
  );

  always_comb begin
    issue_vec = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      gslot[g] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[g*DEPTH+i]) begin
          issue_vec[i] = 1'b1;
          gslot[g]     = SLOT_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid_q <= '0;
      ret_valid_q <= 1'b0;
    end else begin
      iss_valid_q <= fire;
      ret_valid_q <= ret_ok;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < N_GROUPS; g++) begin
      iss_slot_q[g*SLOT_W +: SLOT_W] <= gslot[g];
      iss_id_q[g*ID_W +: ID_W]       <= sid[gslot[g]];
      iss_unit_q[g*UNIT_W +: UNIT_W] <= unit_pick[g];
    end
    ret_id_q <= sid[cmpl_slot];
  end

  assign iss_valid = iss_valid_q;
  assign iss_id    = iss_id_q;
  assign iss_slot  = iss_slot_q;
  assign iss_unit  = iss_unit_q;
  assign ret_valid = ret_valid_q;
  assign ret_id    = ret_id_q;

endmodule

// File: rtl/oib_checker.sv
module oib_checker #(
  parameter int N_GROUPS      = 2,
  parameter int UNITS_PER_GRP = 2,
  parameter int SLOT_W        = 3,
  parameter int UNIT_W        = 1
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              full,
  input logic                              cmpl_valid,
  input logic [N_GROUPS*UNITS_PER_GRP-1:0] unit_busy,
  input logic [N_GROUPS-1:0]               iss_valid,
  input logic [N_GROUPS*SLOT_W-1:0]        iss_slot,
  input logic [N_GROUPS*UNIT_W-1:0]        iss_unit,
  input logic                              ret_valid
);

  logic [N_GROUPS*UNITS_PER_GRP-1:0] busy_d;

  always_ff @(posedge clk) busy_d <= unit_busy;

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iss_valid == '0 && !ret_valid && !full));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !cmpl_valid) |=> full);

  p_ret_needs_cmpl_r7: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(cmpl_valid));

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_unit
    p_unit_was_free_r6: assert property (@(posedge clk) disable iff (rst)
      iss_valid[g] |-> !busy_d[g*UNITS_PER_GRP + int'(iss_unit[g*UNIT_W +: UNIT_W])]);
  end

  for (genvar a = 0; a < N_GROUPS; a++) begin : g_pa
    for (genvar b = a + 1; b < N_GROUPS; b++) begin : g_pb
      p_distinct_slots_r5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid[a] && iss_valid[b]) |->
          (iss_slot[a*SLOT_W +: SLOT_W] != iss_slot[b*SLOT_W +: SLOT_W]));
    end
  end

endmodule

bind oo_issue_buffer oib_checker #(
  .N_GROUPS      (N_GROUPS),
  .UNITS_PER_GRP (UNITS_PER_GRP),
  .SLOT_W        (SLOT_W),
  .UNIT_W        (UNIT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .full       (full),
  .cmpl_valid (cmpl_valid),
  .unit_busy  (unit_busy),
  .iss_valid  (iss_valid),
  .iss_slot   (iss_slot),
  .iss_unit   (iss_unit),
  .ret_valid  (ret_valid)
);

// File: tb/tb_oo_issue_buffer.sv
`timescale 1ns/1ps
module tb_oo_issue_buffer;

  localparam int DEPTH = 8;
  localparam int NG    = 2;
  localparam int NU    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_valid = 1'b0;
  logic [7:0]  disp_id = '0;
  logic [0:0]  disp_grp = '0;
  logic [11:0] disp_tags = '0;
  logic [1:0]  disp_rdy = '0;
  logic        full;
  logic        wb_valid = 1'b0;
  logic [5:0]  wb_tag = '0;
  logic [3:0]  unit_busy = '0;
  logic [1:0]  iss_valid;
  logic [15:0] iss_id;
  logic [5:0]  iss_slot;
  logic [1:0]  iss_unit;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_slot = '0;
  logic        ret_valid;
  logic [7:0]  ret_id;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_ptr [NG];
  logic [2:0] kept [DEPTH];

  always #4 clk = ~clk;

  oo_issue_buffer #(
    .DEPTH(DEPTH), .N_SRC(2), .TAG_W(6), .ID_W(8), .N_GROUPS(NG), .UNITS_PER_GRP(NU)
  ) dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_id(disp_id), .disp_grp(disp_grp),
    .disp_tags(disp_tags), .disp_rdy(disp_rdy), .full(full), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .unit_busy(unit_busy), .iss_valid(iss_valid), .iss_id(iss_id),
    .iss_slot(iss_slot), .iss_unit(iss_unit), .cmpl_valid(cmpl_valid),
    .cmpl_slot(cmpl_slot), .ret_valid(ret_valid), .ret_id(ret_id)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic dispatch(input logic [7:0] id, input logic g, input logic [11:0] tags,
                          input logic [1:0] rdy);
    disp_valid = 1'b1; disp_id = id; disp_grp = g; disp_tags = tags; disp_rdy = rdy;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic broadcast(input logic [5:0] tag);
    wb_valid = 1'b1; wb_tag = tag;
    tick();
    wb_valid = 1'b0;
  endtask

  // unit model: first non-busy from pointer, pointer moves past it
  task automatic expect_issue(input string tag, input int g, input logic [7:0] id,
                              output logic [2:0] slot);
    int u;
    u = -1;
    for (int k = NU - 1; k >= 0; k--)
      if (!unit_busy[g*NU + (exp_ptr[g] + k) % NU]) u = (exp_ptr[g] + k) % NU;
    chk({tag, " valid"}, 32'(iss_valid[g]), 1);
    chk({tag, " id"},    32'(iss_id[g*8 +: 8]), 32'(id));
    chk({tag, " unit R6"}, 32'(iss_unit[g]), 32'(u));
    exp_ptr[g] = (u + 1) % NU;
    slot = iss_slot[g*3 +: 3];
  endtask

  task automatic complete(input string tag, input logic [2:0] slot, input logic [7:0] id);
    cmpl_valid = 1'b1; cmpl_slot = slot;
    tick();
    cmpl_valid = 1'b0;
    chk({tag, " R7 ret_valid"}, 32'(ret_valid), 1);
    chk({tag, " R7 ret_id"}, 32'(ret_id), 32'(id));
  endtask

  task automatic t_reset();
    chk("R1 full", 32'(full), 0);
    chk("R1 iss_valid", 32'(iss_valid), 0);
    chk("R1 ret_valid", 32'(ret_valid), 0);
  endtask

  task automatic t_ready_dispatch();
    logic [2:0] s;
    dispatch(8'd10, 1'b0, {6'd1, 6'd2}, 2'b11);
    chk("R2 no issue at first edge", 32'(iss_valid), 0);
    tick();
    expect_issue("R2 R9 ready dispatch", 0, 8'd10, s);
    chk("R9 lane1 idle", 32'(iss_valid[1]), 0);
    tick();
    chk("R2 issues once", 32'(iss_valid), 0);
    complete("ready", s, 8'd10);
  endtask

  task automatic t_wakeup();
    logic [2:0] s;
    dispatch(8'd20, 1'b1, {6'd3, 6'd5}, 2'b10);
    tick();
    chk("R3 waiting", 32'(iss_valid), 0);
    broadcast(6'd6);
    tick();
    chk("R3 non-matching tag ignored", 32'(iss_valid), 0);
    broadcast(6'd5);
    chk("R3 not yet", 32'(iss_valid), 0);
    tick();
    expect_issue("R3 R9 woken", 1, 8'd20, s);
    complete("wakeup", s, 8'd20);
  endtask

  task automatic t_same_cycle();
    logic [2:0] s;
    wb_valid = 1'b1; wb_tag = 6'd7;
    dispatch(8'd30, 1'b0, {6'd9, 6'd7}, 2'b10);
    wb_valid = 1'b0;
    chk("R4 no issue at first edge", 32'(iss_valid), 0);
    tick();
    expect_issue("R4 same-cycle wakeup", 0, 8'd30, s);
    complete("same", s, 8'd30);
  endtask

  task automatic t_age();
    logic [2:0] sx, sa, sb, sp, sq;
    dispatch(8'd50, 1'b0, {6'd0, 6'd11}, 2'b10);   // slot 0
    dispatch(8'd51, 1'b0, {6'd0, 6'd13}, 2'b10);   // slot 1, older
    broadcast(6'd11);
    tick();
    expect_issue("R5 filler", 0, 8'd50, sx);
    complete("filler", sx, 8'd50);
    dispatch(8'd52, 1'b0, {6'd0, 6'd13}, 2'b10);   // reuses slot 0, younger
    broadcast(6'd13);
    tick();
    expect_issue("R5 oldest first", 0, 8'd51, sa);
    tick();
    expect_issue("R5 younger next", 0, 8'd52, sb);
    chk("R5 younger in lower slot", 32'(sb < sa), 1);
    complete("age a", sa, 8'd51);
    complete("age b", sb, 8'd52);
    // parallel issue across groups
    dispatch(8'd60, 1'b0, {6'd0, 6'd12}, 2'b10);
    dispatch(8'd61, 1'b1, {6'd0, 6'd12}, 2'b10);
    broadcast(6'd12);
    tick();
    chk("R5 both lanes", 32'(iss_valid), 3);
    expect_issue("R5 lane0", 0, 8'd60, sp);
    expect_issue("R5 lane1", 1, 8'd61, sq);
    complete("par p", sp, 8'd60);
    complete("par q", sq, 8'd61);
  endtask

  task automatic t_units();
    logic [2:0] s;
    unit_busy = 4'(1) << (1*NU + exp_ptr[1]);      // pointed-to unit of group 1 busy
    dispatch(8'd70, 1'b1, 12'd0, 2'b11);
    tick();
    expect_issue("R6 skip busy", 1, 8'd70, s);
    complete("skip", s, 8'd70);
    unit_busy = 4'b1100;
    dispatch(8'd71, 1'b1, 12'd0, 2'b11);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 all busy no issue", 32'(iss_valid), 0);
    end
    unit_busy = 4'b0000;
    tick();
    expect_issue("R6 released", 1, 8'd71, s);
    complete("rel", s, 8'd71);
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) begin
      chk("R8 not full yet", 32'(full), 0);
      dispatch(8'(80 + k), 1'b0, {6'd20, 6'd20}, 2'b00);
    end
    chk("R8 full", 32'(full), 1);
    dispatch(8'd99, 1'b0, 12'd0, 2'b11);
    chk("R8 still full", 32'(full), 1);
    cmpl_valid = 1'b1; cmpl_slot = 3'd3;
    tick();
    cmpl_valid = 1'b0;
    chk("R7 waiting slot completion ignored", 32'(ret_valid), 0);
    chk("R7 slot kept", 32'(full), 1);
    broadcast(6'd20);
    chk("R8 no issue before wake", 32'(iss_valid), 0);
    for (int k = 0; k < DEPTH; k++) begin
      tick();
      expect_issue("R5 R8 drain in age order", 0, 8'(80 + k), kept[k]);
    end
    tick();
    chk("R8 dropped dispatch never issues", 32'(iss_valid), 0);
    for (int k = 0; k < DEPTH; k++) complete("drain", kept[k], 8'(80 + k));
    chk("R8 empty again", 32'(full), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) exp_ptr[g] = 0;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_ready_dispatch();
    t_wakeup();
    t_same_cycle();
    t_age();
    t_units();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule